// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block decides when the rows of a DRAM device are refreshed, so that every row is rewritten before its charge leaks away. It also keeps refresh and normal traffic apart. A free-running interval timer marks when refresh work is owed. In distributed mode, each mark costs one row and the row pointer moves on by one. In burst mode, a mark arrives once per whole retention window, and the block then stops all traffic and walks every row in consecutive cycles.

The request path asks for access with `acc_req_i` and gets `acc_grant_o` in the same cycle when nothing blocks it. It reports an access still in flight with `acc_busy_i`. A refresh that falls due during a busy access waits until the access ends, and it then goes ahead of any new request. A self-refresh request parks the block with the timer frozen. Once the request is withdrawn, traffic stays blocked for a fixed wake-up time.

Top module: `rfsh_sequencer`

## Requirements
- R1: After reset, `ref_cmd_o`, `stall_o` and `sr_ack_o` are low, `ref_row_o` is 0, and a request is granted in the same cycle.
- R2: In distributed mode with no traffic, `ref_cmd_o` pulses for exactly one cycle every ROW_INTERVAL cycles. The row pointer starts at 0, rises by one after each command and wraps from NUM_ROWS-1 to 0.
- R3: In burst mode, a sweep starts every NUM_ROWS*ROW_INTERVAL cycles. It issues exactly NUM_ROWS commands in consecutive cycles on consecutive rows, and `stall_o` is high in every one of them.
- R4: A refresh owed while `acc_busy_i` is high is held back, with `stall_o` high and no grant. Its command appears in the cycle after the first cycle in which `acc_busy_i` is low.
- R5: `acc_grant_o` follows `acc_req_i` only while `stall_o` is low and `sr_req_i` is low. A grant never coincides with a refresh command.
- R6: `mode_burst_i` (1 = burst, 0 = distributed) is taken only when a refresh sequence ends. The sequence that is next due still runs in the old mode.
- R7: A self-refresh request made while idle, with no access in flight and no refresh owed, raises `sr_ack_o` in the next cycle. While `sr_ack_o` is high, no command and no grant is issued, and `stall_o` is high.
- R8: After `sr_req_i` falls, `sr_ack_o` drops in the next cycle. `stall_o` then stays high, and grants stay blocked, for SR_EXIT_CYCLES cycles. The row pointer is kept, and the first refresh follows ROW_INTERVAL+1 cycles after the first unstalled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_burst_i | input | 1 | Refresh mode wanted: 1 burst, 0 distributed |
| acc_req_i | input | 1 | Request path wants to issue an access |
| acc_busy_i | input | 1 | An access is still in flight |
| acc_grant_o | output | 1 | Access may be issued this cycle |
| stall_o | output | 1 | Traffic is held off for refresh or self-refresh |
| ref_cmd_o | output | 1 | Refresh one row this cycle |
| ref_row_o | output | ROW_W | Row to refresh |
| sr_req_i | input | 1 | Request to enter self-refresh (level) |
| sr_ack_o | output | 1 | Block is parked in self-refresh |

## Verification
The grant is combinational, so the bench checks it right after driving a request. A refresh command appears one cycle after the cycle in which the owed flag is seen: two registers lie between the timer's terminal count and the command. The bench therefore measures spacing between commands as a difference of cycle counts, and it measures postponement from the first cycle in which stall is seen. Self-refresh acknowledge follows one cycle after the request. The wake-up window is counted as SR_EXIT_CYCLES samples taken at falling edges, followed by one sample in which traffic is free again. All samples are taken at the falling edge, halfway between register updates.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ROW   = 3'd1,
        ST_BURST = 3'd2,
        ST_SELF  = 3'd3,
        ST_WAKE  = 3'd4
    } rfsh_state_e;

    typedef struct packed {
        rfsh_state_e state;
        logic        burst_mode;
    } rfsh_ctl_t;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned NUM_ROWS     = 8,
    parameter int unsigned ROW_INTERVAL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic burst_sel_i,
    input  logic take_i,
    output logic due_o
);
    localparam int unsigned BURST_PERIOD = NUM_ROWS * ROW_INTERVAL;
    localparam int unsigned CW           = $clog2(BURST_PERIOD + 1);
    localparam logic [CW-1:0] ROW_LIM    = CW'(ROW_INTERVAL - 1);
    localparam logic [CW-1:0] SWEEP_LIM  = CW'(BURST_PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          due;
    } tmr_t;

    tmr_t          tmr_d, tmr_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = burst_sel_i ? SWEEP_LIM : ROW_LIM;
        tmr_d = tmr_q;
        if (hold_i) begin
            tmr_d.cnt = '0;
            tmr_d.due = 1'b0;
        end else begin
            if (take_i) begin
                tmr_d.due = 1'b0;
            end
            if (tmr_q.cnt >= limit) begin
                tmr_d.cnt = '0;
                tmr_d.due = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign due_o = tmr_q.due;

endmodule

// File: rtl/rfsh_row_walker.sv
module rfsh_row_walker #(
    parameter int unsigned NUM_ROWS = 8,
    localparam int unsigned RW      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          in_burst_i,
    output logic [RW-1:0] row_o,
    output logic          last_o
);
    localparam logic [RW-1:0] LAST = RW'(NUM_ROWS - 1);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [RW-1:0] bcnt;
    } walk_t;

    walk_t         walk_d, walk_q;
    logic [RW-1:0] row_inc;
    logic [RW-1:0] bcnt_inc;

    generate
        if ((NUM_ROWS & (NUM_ROWS - 1)) == 0) begin : g_pow2
            assign row_inc  = walk_q.row + 1'b1;
            assign bcnt_inc = walk_q.bcnt + 1'b1;
        end else begin : g_cmp
            assign row_inc  = (walk_q.row == LAST) ? '0 : walk_q.row + 1'b1;
            assign bcnt_inc = (walk_q.bcnt == LAST) ? '0 : walk_q.bcnt + 1'b1;
        end
    endgenerate

    always_comb begin
        walk_d = walk_q;
        if (adv_i) begin
            walk_d.row = row_inc;
        end
        if (adv_i && in_burst_i) begin
            walk_d.bcnt = bcnt_inc;
        end else begin
            walk_d.bcnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign row_o  = walk_q.row;
    assign last_o = (walk_q.bcnt == LAST);

endmodule

// File: rtl/rfsh_wake_timer.sv
module rfsh_wake_timer #(
    parameter int unsigned SR_EXIT_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned XW = (SR_EXIT_CYCLES > 1) ? $clog2(SR_EXIT_CYCLES) : 1;
    localparam logic [XW-1:0] XLAST = XW'(SR_EXIT_CYCLES - 1);

    logic [XW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i && (cnt_q != XLAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = run_i && (cnt_q == XLAST);

endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
    import rfsh_pkg::*;
#(
    parameter int unsigned NUM_ROWS       = 8,
    parameter int unsigned ROW_INTERVAL   = 16,
    parameter int unsigned SR_EXIT_CYCLES = 5,
    localparam int unsigned ROW_W         = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_burst_i,
    input  logic             acc_req_i,
    input  logic             acc_busy_i,
    output logic             acc_grant_o,
    output logic             stall_o,
    output logic             ref_cmd_o,
    output logic [ROW_W-1:0] ref_row_o,
    input  logic             sr_req_i,
    output logic             sr_ack_o
);
    rfsh_ctl_t ctl_d, ctl_q;
    logic      due;
    logic      take;
    logic      sweep_last;
    logic      wake_done;
    logic      hold;
    logic      in_burst;

    assign hold      = (ctl_q.state == ST_SELF) || (ctl_q.state == ST_WAKE);
    assign in_burst  = (ctl_q.state == ST_BURST);
    assign ref_cmd_o = (ctl_q.state == ST_ROW) || in_burst;

    rfsh_interval_timer #(
        .NUM_ROWS     (NUM_ROWS),
        .ROW_INTERVAL (ROW_INTERVAL)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold),
        .burst_sel_i (ctl_q.burst_mode),
        .take_i      (take),
        .due_o       (due)
    );

    rfsh_row_walker #(
        .NUM_ROWS (NUM_ROWS)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (ref_cmd_o),
        .in_burst_i (in_burst),
        .row_o      (ref_row_o),
        .last_o     (sweep_last)
    );

    rfsh_wake_timer #(
        .SR_EXIT_CYCLES (SR_EXIT_CYCLES)
    ) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ctl_q.state == ST_WAKE),
        .done_o (wake_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        take  = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (due) begin
                    if (!acc_busy_i) begin
                        take        = 1'b1;
                        ctl_d.state = ctl_q.burst_mode ? ST_BURST : ST_ROW;
                    end
                end else if (sr_req_i && !acc_busy_i) begin
                    ctl_d.state = ST_SELF;
                end
            end
            ST_ROW: begin
                ctl_d.state      = ST_IDLE;
                ctl_d.burst_mode = mode_burst_i;
            end
            ST_BURST: begin
                if (sweep_last) begin
                    ctl_d.state      = ST_IDLE;
                    ctl_d.burst_mode = mode_burst_i;
                end
            end
            ST_SELF: begin
                if (!sr_req_i) begin
                    ctl_d.state = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (wake_done) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state      <= ST_IDLE;
            ctl_q.burst_mode <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign stall_o     = (ctl_q.state != ST_IDLE) || due;
    assign acc_grant_o = acc_req_i && (ctl_q.state == ST_IDLE) && !due && !sr_req_i;
    assign sr_ack_o    = (ctl_q.state == ST_SELF);

endmodule

// File: rtl/rfsh_sequencer_chk.sv
module rfsh_sequencer_chk #(
    parameter int unsigned NUM_ROWS       = 8,
    parameter int unsigned SR_EXIT_CYCLES = 5,
    localparam int unsigned RW            = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_busy_i,
    input logic          acc_grant_o,
    input logic          stall_o,
    input logic          ref_cmd_o,
    input logic [RW-1:0] ref_row_o,
    input logic          sr_ack_o
);
    localparam int unsigned RUN_W = $clog2(NUM_ROWS + 2);
    localparam int unsigned WW    = $clog2(SR_EXIT_CYCLES + 1);
    localparam logic [RW-1:0] LAST_ROW = RW'(NUM_ROWS - 1);

    logic [RUN_W-1:0] run_q;
    logic [WW-1:0]    win_q;
    logic             ack_prev_q;
    logic             ack_fall;
    logic             in_window;

    assign ack_fall  = ack_prev_q && !sr_ack_o;
    assign in_window = ack_fall || (win_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= '0;
            win_q      <= '0;
            ack_prev_q <= 1'b0;
        end else begin
            run_q      <= ref_cmd_o ? run_q + 1'b1 : '0;
            ack_prev_q <= sr_ack_o;
            if (ack_fall) begin
                win_q <= WW'(SR_EXIT_CYCLES - 1);
            end else if (win_q != '0) begin
                win_q <= win_q - 1'b1;
            end
        end
    end

    p_cmd_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd_o |-> stall_o);

    p_sweep_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(NUM_ROWS));

    p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ref_cmd_o) |-> (ref_row_o == (($past(ref_row_o) == LAST_ROW) ? '0 : $past(ref_row_o) + 1'b1)));

    p_idle_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ref_cmd_o) |-> $stable(ref_row_o));

    p_no_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_cmd_o) |-> !$past(acc_busy_i));

    p_no_grant_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd_o |-> !acc_grant_o);

    p_self_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack_o |-> (!acc_grant_o && !ref_cmd_o && stall_o));

    p_wake_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_window |-> (stall_o && !acc_grant_o && !sr_ack_o));

endmodule

bind rfsh_sequencer rfsh_sequencer_chk #(
    .NUM_ROWS       (NUM_ROWS),
    .SR_EXIT_CYCLES (SR_EXIT_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_busy_i  (acc_busy_i),
    .acc_grant_o (acc_grant_o),
    .stall_o     (stall_o),
    .ref_cmd_o   (ref_cmd_o),
    .ref_row_o   (ref_row_o),
    .sr_ack_o    (sr_ack_o)
);

// File: tb/sim_rfsh_sequencer.sv
module sim_rfsh_sequencer;
    localparam int NR = 8;
    localparam int RI = 16;
    localparam int XC = 5;
    localparam int BP = NR * RI;
    localparam int RWB = $clog2(NR);

    // postponement vectors: {busy cycles after owed flag seen, expected cycles to command}
    localparam int PP [4][2] = '{'{1, 2}, '{2, 3}, '{4, 5}, '{7, 8}};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_burst_i = 1'b0;
    logic           acc_req_i = 1'b0;
    logic           acc_busy_i = 1'b0;
    logic           sr_req_i = 1'b0;
    logic           acc_grant_o;
    logic           stall_o;
    logic           ref_cmd_o;
    logic [RWB-1:0] ref_row_o;
    logic           sr_ack_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int erow = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rfsh_sequencer #(
        .NUM_ROWS       (NR),
        .ROW_INTERVAL   (RI),
        .SR_EXIT_CYCLES (XC)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_burst_i (mode_burst_i),
        .acc_req_i    (acc_req_i),
        .acc_busy_i   (acc_busy_i),
        .acc_grant_o  (acc_grant_o),
        .stall_o      (stall_o),
        .ref_cmd_o    (ref_cmd_o),
        .ref_row_o    (ref_row_o),
        .sr_req_i     (sr_req_i),
        .sr_ack_o     (sr_ack_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic wait_cmd(output int at);
        int n = 0;
        do begin
            step();
            n++;
        end while (!ref_cmd_o && n < 1000);
        if (!ref_cmd_o) chk("R2 command timeout", 0, 1);
        at = cyc;
    endtask

    task automatic seen_row(input string tag);
        chk(tag, int'(ref_row_o), erow);
        erow = (erow + 1) % NR;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got %0d expected 0", 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t;
        int prev;
        int t0;
        int n;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 ref_cmd", int'(ref_cmd_o), 0);
        chk("R1 stall", int'(stall_o), 0);
        chk("R1 sr_ack", int'(sr_ack_o), 0);
        chk("R1 row", int'(ref_row_o), 0);
        acc_req_i = 1'b1;
        #1;
        chk("R1 R5 grant", int'(acc_grant_o), 1);

        // R2 distributed spacing, single-cycle pulses, row wrap
        wait_cmd(prev);
        seen_row("R2 first row");
        chk("R5 no grant during command", int'(acc_grant_o), 0);
        for (int k = 0; k < NR + 1; k++) begin
            step();
            chk("R2 single cycle", int'(ref_cmd_o), 0);
            wait_cmd(t);
            chk("R2 spacing", t - prev, RI);
            seen_row("R2 row order");
            prev = t;
        end

        // R4 postponement vectors
        for (int i = 0; i < 4; i++) begin
            acc_busy_i = 1'b1;
            n = 0;
            do begin
                step();
                n++;
            end while (!stall_o && n < 1000);
            t0 = cyc;
            chk("R4 no command while busy", int'(ref_cmd_o), 0);
            chk("R4 no grant while owed", int'(acc_grant_o), 0);
            repeat (PP[i][0] - 1) step();
            step();
            chk("R4 still held", int'(ref_cmd_o), 0);
            chk("R4 still stalled", int'(stall_o), 1);
            acc_busy_i = 1'b0;
            step();
            chk("R4 command after busy", int'(ref_cmd_o), 1);
            chk("R4 delay", cyc - t0, PP[i][1]);
            seen_row("R4 row");
        end
        prev = cyc;

        // R6 mode change waits for a sequence boundary
        repeat (3) step();
        mode_burst_i = 1'b1;
        wait_cmd(t);
        seen_row("R6 row");
        step();
        chk("R6 old mode still single", int'(ref_cmd_o), 0);
        wait_cmd(prev);
        chk("R3 sweep start spacing", prev - t, BP);
        // R3 sweep content
        for (int j = 0; j < NR; j++) begin
            if (j > 0) step();
            chk("R3 consecutive command", int'(ref_cmd_o), 1);
            chk("R3 stall in sweep", int'(stall_o), 1);
            chk("R5 no grant in sweep", int'(acc_grant_o), 0);
            seen_row("R3 sweep row");
        end
        step();
        chk("R3 exactly NUM_ROWS", int'(ref_cmd_o), 0);
        mode_burst_i = 1'b0;
        wait_cmd(t);
        chk("R3 R6 second sweep spacing", t - prev, BP);
        n = 0;
        while (ref_cmd_o) begin
            seen_row("R3 second sweep row");
            n++;
            step();
        end
        chk("R6 second sweep still full", n, NR);
        wait_cmd(prev);
        chk("R6 back to distributed spacing", prev - t, RI);
        seen_row("R6 row after sweep");
        step();
        chk("R6 single again", int'(ref_cmd_o), 0);

        // R7 self-refresh entry and quiet period
        sr_req_i = 1'b1;
        step();
        chk("R7 ack", int'(sr_ack_o), 1);
        chk("R7 stall", int'(stall_o), 1);
        chk("R7 no grant", int'(acc_grant_o), 0);
        n = 0;
        repeat (3 * RI) begin
            step();
            if (ref_cmd_o || !sr_ack_o) n++;
        end
        chk("R7 no command while parked", n, 0);
        sr_req_i = 1'b0;

        // R8 timed exit
        step();
        chk("R8 ack drops", int'(sr_ack_o), 0);
        n = 0;
        for (int j = 1; j < XC; j++) begin
            if (!stall_o || acc_grant_o) n++;
            step();
        end
        if (!stall_o || acc_grant_o) n++;
        chk("R8 blocked for exit window", n, 0);
        step();
        chk("R8 stall released", int'(stall_o), 0);
        chk("R8 grant restored", int'(acc_grant_o), 1);
        t0 = cyc;
        wait_cmd(t);
        chk("R8 first refresh delay", t - t0, RI + 1);
        seen_row("R8 row kept");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule